// File: doc/BRIEF.md
# Multi-Word Control Store Access Sequencer

This block steps a host read or write command through the cycles needed to reach a wide control store. The store is reached one 16-bit slice at a time. A 4-bit slice number chooses which part of the word is being handled. Slices 0 to 7 are parts of the store word itself. Slices 10 and up select a temporary holding register instead. Slices 8 and 9 lie between the two ranges. For each clock, the sequencer looks at its own state, the command levels and the slice number supplied by the surrounding logic. From these it produces the strobes that read the store address, enable the store read and write paths, load or read the temporary register, and stall the processor run signal.

A command runs through six states. Command detection comes first, then two access cycles, then two drain cycles, and finally a completion state. The sequencer waits in the completion state until the host drops the command. When the command drops, the block computes the next slice number. If the last store slice has just finished, the number wraps to zero and the block pulses the address-advance strobe. All outputs, including the next slice number, are registered. Each output therefore shows the decision taken at the previous clock edge. The outer logic is expected to load `slice_out` back into `slice_in`.

Top module: `cstore_access_seq`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) puts the state at idle (0) and `slice_out` at 0. At the same edge it drives `run_en`, `temp_wr`, `store_wr_en` and `store_rd_en` to 0, and `addr_rd_n`, `addr_inc_n` and `temp_rd_n` to 1.
- R2: In idle with neither command active, the state stays idle. The next outputs are then `run_en`=1 with every strobe inactive.
- R3: In idle with `rd_cmd` or `wr_cmd` high, the state moves to 1. If `slice_in` ≤ 7 in that cycle, the next outputs have `run_en`=0 and `addr_rd_n`=0; otherwise `run_en` stays 1.
- R4: In states 1 and 2, `store_rd_en` goes to 1 in either of two cases. The first is a write with 2 ≤ `slice_in` ≤ 7. The second is a read with `slice_in` ≤ 9.
- R5: In states 1 and 2, `slice_in` ≤ 7 gives `run_en`=0 and `addr_rd_n`=0. In state 2 only, `store_wr_en` is 1 when `wr_cmd` is high and `slice_in` ≤ 7.
- R6: In states 1 and 2, a read with `slice_in` ≥ 10 gives `temp_rd_n`=0. In state 2, in every other case `temp_wr`=1 instead. `temp_wr`=1 and `temp_rd_n`=0 never occur together.
- R7: States 1, 2, 3 and 4 always advance to the next state, whatever the command levels. In states 3 and 4, `slice_in` ≤ 7 gives `run_en`=0, and `rd_cmd` gives `temp_rd_n`=0.
- R8: In state 5 with a command still active, the state holds at 5. In this case `temp_rd_n`=0 if `rd_cmd` is high.
- R9: In state 5 with both commands low, the state returns to idle and `slice_out` is updated. It becomes 0 with `addr_inc_n`=0 when `slice_in` = 7. Otherwise it becomes `slice_in`+1 when `slice_in` < 10, and stays `slice_in` when `slice_in` ≥ 10.
- R10: Outside the state-5 completion cycle, `slice_out` equals the `slice_in` of the previous cycle, and `addr_inc_n` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_cmd | input | 1 | Host read command level |
| wr_cmd | input | 1 | Host write command level |
| slice_in | input | 4 | Current slice number |
| slice_out | output | 4 | Registered next slice number |
| run_en | output | 1 | Processor run enable, active high |
| addr_rd_n | output | 1 | Store address read strobe, active low |
| addr_inc_n | output | 1 | Store address advance pulse, active low |
| temp_wr | output | 1 | Temporary register load, active high |
| temp_rd_n | output | 1 | Temporary register read, active low |
| store_wr_en | output | 1 | Store write enable, active high |
| store_rd_en | output | 1 | Store read enable, active high |

## Verification
On every cycle, the assertions check four things. Reset lands on idle with inactive strobes. The drain states step forward. A temporary load and a temporary read never occur together. An address advance only appears with a wrapped slice number, and a write enable or stall only follows the state and slice conditions that allow it. Only the bench's scenarios can show that the full table is correct. The bench sweeps every slice value against read, write and combined commands, held for different lengths. This covers the hold in state 5, the boundaries at slices 2, 7, 9 and 10, and the wrap from 7 to 0 with its strobe. A closed feedback loop of slice numbers then exercises consecutive transactions.

// File: rtl/cstore_seq_pkg.sv
package cstore_seq_pkg;

    localparam int SLICE_W = 4;
    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE    = 3'd0,
        ST_ISSUE   = 3'd1,
        ST_COMMIT  = 3'd2,
        ST_DRAIN_A = 3'd3,
        ST_DRAIN_B = 3'd4,
        ST_FINISH  = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic run_en;
        logic addr_rd_n;
        logic addr_inc_n;
        logic temp_wr;
        logic temp_rd_n;
        logic store_wr_en;
        logic store_rd_en;
    } strobe_t;

    // Every strobe at its inactive level, run held off (reset value).
    function automatic strobe_t strobe_reset();
        strobe_t s;
        s.run_en      = 1'b0;
        s.addr_rd_n   = 1'b1;
        s.addr_inc_n  = 1'b1;
        s.temp_wr     = 1'b0;
        s.temp_rd_n   = 1'b1;
        s.store_wr_en = 1'b0;
        s.store_rd_en = 1'b0;
        return s;
    endfunction

    // Default in-sequence value: run on, strobes idle.
    function automatic strobe_t strobe_quiet();
        strobe_t s;
        s        = strobe_reset();
        s.run_en = 1'b1;
        return s;
    endfunction

endpackage

// File: rtl/cstore_seq_decode.sv
module cstore_seq_decode
    import cstore_seq_pkg::*;
#(
    parameter int SW          = SLICE_W,
    parameter int LAST_STORE  = 7,
    parameter int TEMP_BASE   = 10,
    parameter int WR_RD_FLOOR = 2
) (
    input  seq_state_e    state,
    input  logic [SW-1:0] slice,
    input  logic          rd,
    input  logic          wr,
    output seq_state_e    next_state,
    output logic [SW-1:0] next_slice,
    output strobe_t       next_strobe
);
    localparam logic [SW-1:0] LAST_S  = SW'(LAST_STORE);
    localparam logic [SW-1:0] TEMP_S  = SW'(TEMP_BASE);
    localparam logic [SW-1:0] FLOOR_S = SW'(WR_RD_FLOOR);
    localparam logic [SW-1:0] ONE_S   = SW'(1);

    logic cmd, in_store, rd_path, temp_hit;

    always_comb begin
        cmd      = rd | wr;
        in_store = (slice <= LAST_S);
        rd_path  = (wr && slice >= FLOOR_S && in_store) || (rd && slice < TEMP_S);
        temp_hit = rd && (slice >= TEMP_S);
    end

    always_comb begin
        next_state  = state;
        next_slice  = slice;
        next_strobe = strobe_quiet();
        unique case (state)
            ST_IDLE: begin
                if (cmd) begin
                    next_state = ST_ISSUE;
                    if (in_store) begin
                        next_strobe.run_en    = 1'b0;
                        next_strobe.addr_rd_n = 1'b0;
                    end
                end
            end
            ST_ISSUE, ST_COMMIT: begin
                next_strobe.store_rd_en = rd_path;
                if (in_store) begin
                    next_strobe.run_en    = 1'b0;
                    next_strobe.addr_rd_n = 1'b0;
                end
                if (temp_hit) begin
                    next_strobe.temp_rd_n = 1'b0;
                end else if (state == ST_COMMIT) begin
                    next_strobe.temp_wr = 1'b1;
                end
                if (state == ST_COMMIT) begin
                    next_strobe.store_wr_en = wr && in_store;
                    next_state = ST_DRAIN_A;
                end else begin
                    next_state = ST_COMMIT;
                end
            end
            ST_DRAIN_A, ST_DRAIN_B: begin
                if (in_store) next_strobe.run_en    = 1'b0;
                if (rd)       next_strobe.temp_rd_n = 1'b0;
                next_state = (state == ST_DRAIN_A) ? ST_DRAIN_B : ST_FINISH;
            end
            ST_FINISH: begin
                if (cmd) begin
                    if (rd) next_strobe.temp_rd_n = 1'b0;
                end else begin
                    if (slice < TEMP_S) next_slice = slice + ONE_S;
                    if (slice == LAST_S) begin
                        next_slice             = '0;
                        next_strobe.addr_inc_n = 1'b0;
                    end
                    next_state = ST_IDLE;
                end
            end
            default: next_state = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/cstore_seq_state_reg.sv
module cstore_seq_state_reg
    import cstore_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  seq_state_e d,
    output seq_state_e q
);
    always_ff @(posedge clk) begin
        if (rst) q <= ST_IDLE;
        else     q <= d;
    end

    assert_reset_idle_R1: assert property (@(posedge clk) rst |=> (q == ST_IDLE));
    assert_drain_steps_R7: assert property (@(posedge clk) disable iff (rst)
        (q == ST_DRAIN_A) |=> (q == ST_DRAIN_B));
    assert_issue_steps_R7: assert property (@(posedge clk) disable iff (rst)
        (q == ST_ISSUE) |=> (q == ST_COMMIT));
endmodule

// File: rtl/cstore_seq_out_reg.sv
module cstore_seq_out_reg
    import cstore_seq_pkg::*;
#(
    parameter int SW = SLICE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] slice_d,
    input  strobe_t       strobe_d,
    output logic [SW-1:0] slice_q,
    output strobe_t       strobe_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            slice_q  <= '0;
            strobe_q <= strobe_reset();
        end else begin
            slice_q  <= slice_d;
            strobe_q <= strobe_d;
        end
    end

    assert_reset_strobes_R1: assert property (@(posedge clk)
        rst |=> (strobe_q == strobe_reset() && slice_q == '0));
    assert_temp_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(strobe_q.temp_wr && !strobe_q.temp_rd_n));
    assert_inc_wraps_R9: assert property (@(posedge clk) disable iff (rst)
        !strobe_q.addr_inc_n |-> (slice_q == '0));
endmodule

// File: rtl/cstore_access_seq.sv
module cstore_access_seq
    import cstore_seq_pkg::*;
#(
    parameter int SW          = SLICE_W,
    parameter int LAST_STORE  = 7,
    parameter int TEMP_BASE   = 10,
    parameter int WR_RD_FLOOR = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_cmd,
    input  logic          wr_cmd,
    input  logic [SW-1:0] slice_in,
    output logic [SW-1:0] slice_out,
    output logic          run_en,
    output logic          addr_rd_n,
    output logic          addr_inc_n,
    output logic          temp_wr,
    output logic          temp_rd_n,
    output logic          store_wr_en,
    output logic          store_rd_en
);
    localparam logic [SW-1:0] LAST_S = SW'(LAST_STORE);

    seq_state_e    state_q, state_d;
    logic [SW-1:0] slice_d;
    strobe_t       strobe_d, strobe_q;

    cstore_seq_decode #(
        .SW(SW), .LAST_STORE(LAST_STORE), .TEMP_BASE(TEMP_BASE), .WR_RD_FLOOR(WR_RD_FLOOR)
    ) u_decode (
        .state(state_q), .slice(slice_in), .rd(rd_cmd), .wr(wr_cmd),
        .next_state(state_d), .next_slice(slice_d), .next_strobe(strobe_d)
    );

    cstore_seq_state_reg u_state (
        .clk(clk), .rst(rst), .d(state_d), .q(state_q)
    );

    cstore_seq_out_reg #(.SW(SW)) u_out (
        .clk(clk), .rst(rst), .slice_d(slice_d), .strobe_d(strobe_d),
        .slice_q(slice_out), .strobe_q(strobe_q)
    );

    assign run_en      = strobe_q.run_en;
    assign addr_rd_n   = strobe_q.addr_rd_n;
    assign addr_inc_n  = strobe_q.addr_inc_n;
    assign temp_wr     = strobe_q.temp_wr;
    assign temp_rd_n   = strobe_q.temp_rd_n;
    assign store_wr_en = strobe_q.store_wr_en;
    assign store_rd_en = strobe_q.store_rd_en;

    assert_store_wr_origin_R5: assert property (@(posedge clk) disable iff (rst)
        store_wr_en |-> ($past(state_q) == ST_COMMIT && $past(wr_cmd) && $past(slice_in) <= LAST_S));
    assert_stall_needs_store_slice_R3: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !$past(rst)) |-> ($past(slice_in) <= LAST_S));
    assert_finish_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FINISH && (rd_cmd || wr_cmd)) |=> (state_q == ST_FINISH));
endmodule

// File: tb/sim_cstore_access_seq.sv
module sim_cstore_access_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rd_cmd = 1'b0, wr_cmd = 1'b0;
    logic [3:0] slice_in = 4'd0;
    logic [3:0] slice_out;
    logic run_en, addr_rd_n, addr_inc_n, temp_wr, temp_rd_n, store_wr_en, store_rd_en;

    int tests = 0, fails = 0;
    int m_state = 0;
    int e_slice, e_run, e_ard, e_ainc, e_twr, e_trd, e_swr, e_srd, m_next;
    string t_slice, t_base, t_srd, t_tmp, t_ctl;

    always #4 clk = ~clk;

    cstore_access_seq u0 (
        .clk(clk), .rst(rst), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .slice_in(slice_in),
        .slice_out(slice_out), .run_en(run_en), .addr_rd_n(addr_rd_n), .addr_inc_n(addr_inc_n),
        .temp_wr(temp_wr), .temp_rd_n(temp_rd_n), .store_wr_en(store_wr_en), .store_rd_en(store_rd_en)
    );

    task automatic chk(input string tag, input string nm, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d (state %0d)", tag, nm, act, exp, m_state);
        end
    endtask

    // Expected next outputs derived from the requirement list.
    task automatic predict(input int st, input int r, input int w, input int sl);
        int c;
        c = r | w;
        e_slice = sl; e_run = 1; e_ard = 1; e_ainc = 1; e_twr = 0; e_trd = 1; e_swr = 0; e_srd = 0;
        m_next = st; t_slice = "R10";
        if (st == 0) begin
            t_base = c ? "R3" : "R2"; t_srd = t_base; t_tmp = t_base; t_ctl = t_base;
            if (c) begin m_next = 1; if (sl <= 7) begin e_run = 0; e_ard = 0; end end
        end else if (st == 1 || st == 2) begin
            t_srd = "R4"; t_tmp = "R6"; t_ctl = "R5"; t_base = "R5";
            if ((w && sl >= 2 && sl <= 7) || (r && sl <= 9)) e_srd = 1;
            if (sl <= 7) begin e_run = 0; e_ard = 0; if (st == 2 && w) e_swr = 1; end
            if (r && sl >= 10) e_trd = 0;
            else if (st == 2) e_twr = 1;
            m_next = st + 1;
        end else if (st == 3 || st == 4) begin
            t_base = "R7"; t_srd = t_base; t_tmp = t_base; t_ctl = t_base;
            if (sl <= 7) e_run = 0;
            if (r) e_trd = 0;
            m_next = st + 1;
        end else begin
            t_base = c ? "R8" : "R9"; t_srd = t_base; t_tmp = t_base; t_ctl = t_base;
            if (c) begin
                if (r) e_trd = 0;
            end else begin
                t_slice = "R9";
                if (sl == 7) begin e_slice = 0; e_ainc = 0; end
                else if (sl < 10) e_slice = sl + 1;
                m_next = 0;
            end
        end
    endtask

    // Called just after a falling edge: drive, step one rising edge, check at next falling edge.
    task automatic cycle(input int r, input int w, input int sl);
        rd_cmd = r[0]; wr_cmd = w[0]; slice_in = sl[3:0];
        predict(m_state, r, w, sl);
        @(posedge clk);
        m_state = m_next;
        @(negedge clk);
        chk(t_slice, "slice_out", slice_out, e_slice);
        chk(t_slice, "addr_inc_n", addr_inc_n, e_ainc);
        chk(t_ctl, "run_en", run_en, e_run);
        chk(t_ctl, "addr_rd_n", addr_rd_n, e_ard);
        chk(t_ctl, "store_wr_en", store_wr_en, e_swr);
        chk(t_srd, "store_rd_en", store_rd_en, e_srd);
        chk(t_tmp, "temp_wr", temp_wr, e_twr);
        chk(t_tmp, "temp_rd_n", temp_rd_n, e_trd);
    endtask

    task automatic transaction(input int r, input int w, input int sl, input int hold);
        for (int k = 0; k < hold; k++) cycle(r, w, sl);
        cycle(0, 0, sl);
        while (m_state != 0) cycle(0, 0, sl);
        cycle(0, 0, sl);
    endtask

    initial begin
        rst = 1'b1; slice_in = 4'd9; rd_cmd = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        chk("R1", "slice_out", slice_out, 0);
        chk("R1", "run_en", run_en, 0);
        chk("R1", "addr_rd_n", addr_rd_n, 1);
        chk("R1", "addr_inc_n", addr_inc_n, 1);
        chk("R1", "temp_wr", temp_wr, 0);
        chk("R1", "temp_rd_n", temp_rd_n, 1);
        chk("R1", "store_wr_en", store_wr_en, 0);
        chk("R1", "store_rd_en", store_rd_en, 0);
        rst = 1'b0; m_state = 0;
        cycle(0, 0, 0); // R2 idle

        // Sweep every slice against read, write and both; vary hold length (early drop to long hold).
        for (int sl = 0; sl < 16; sl++)
            for (int c = 1; c < 4; c++)
                for (int h = 1; h < 9; h += 3)
                    transaction(c & 1, (c >> 1) & 1, sl, h + (sl % 3));

        // Closed loop: slice_out fed back, several back-to-back transactions through the wrap.
        for (int i = 0; i < 24; i++)
            transaction(i % 2, (i / 2) % 2 | ((i % 2) == 0 ? 1 : 0), int'(slice_out), 1 + (i % 7));

        // Mid-sequence reset returns to R1 state.
        cycle(1, 0, 3); cycle(1, 0, 3);
        rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0; m_state = 0;
        chk("R1", "run_en after mid reset", run_en, 0);
        chk("R1", "slice_out after mid reset", slice_out, 0);
        cycle(0, 0, 4); // R2 back in idle

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1600000;
        tests++; fails++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule